// File: doc/BRIEF.md
# Register-Bus Address Translating Bridge

The bridge sits between a host that issues 64-bit memory-mapped reads and writes and an internal register bus addressed by a compact register index. For each host access it masks the address to the bridge window and folds it into an index using one of two schemes chosen by a mode input. It then either answers the access itself from a small fixed intercept table or passes it to a downstream register port at byte address `index << 3`.

The host raises a request and holds it until the bridge returns a one-cycle acknowledge; only one access is in flight at a time. Forwarded accesses use a valid/ready request and a response carrying data and an error flag. Outcomes are recorded in two sticky status bits, done and fail, which the bridge only ever sets. A separate write-one-to-clear input clears them. Data words pass through unchanged in big-endian byte order. Only whole 8-byte accesses exist, so address bits [2:0] are ignored.

Top module: `regbus_bridge`

## Requirements
- R1: With `modeSel`=0 the register index is the window-masked address shifted right by 3, so a forwarded access uses `dnAddr` = masked address with bits [2:0] cleared.
- R2: With `modeSel`=1 the index is ((a >> 4) with its low 4 bits cleared) OR ((a >> 3) AND 0xF), where a is the masked address. Address bit 7 has no effect in this mode.
- R3: Host address bits at and above `WIN_BITS` (default 32) do not affect the index.
- R4: A read of index 0xF000F returns the `CHIP_ID` parameter and raises no downstream request.
- R5: Reads of indices 0x1010C00, 0x1010C03, 0x2020007, 0x2020009, 0x202000F, 0x2013028, 0x201302A, 0x2013801, 0x2013802 and 0x2013F00 through 0x2013F07 return zero and raise no downstream request. Writes to those indices that are not listed in R6 are forwarded.
- R6: Writes to indices 0xF000F, 0x2020007, 0x2020009, 0x202000F and 0x1010C00 through 0x1010C05 are discarded with no downstream request. Reads of 0x1010C01, 0x1010C02, 0x1010C04 and 0x1010C05 are forwarded.
- R7: Every other access drives `dnReqValid` until `dnReqReady` is seen, with `dnAddr` = index << 3, and with `dnWrite` and `dnWdata` equal to the host's values. Each host access makes exactly one downstream request.
- R8: A forwarded read without error returns `dnRspData` on `hostRdata`. A response with `dnRspErr`=1 sets both `statFail` and `statDone`, and a read then returns zero.
- R9: Any access that completes without error sets `statDone` and leaves `statFail` unchanged. The bits stay set until `statClr[0]` (done) or `statClr[1]` (fail) is pulsed, and each clear bit affects only its own status bit.
- R10: After reset `hostAck`, `dnReqValid`, `statDone` and `statFail` are 0.
- R11: `hostAck` is a single-cycle pulse, with `hostRdata` valid in that cycle. For a locally answered access it comes two clock edges after the edge that samples `hostReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 1 | Address folding scheme: 0 plain shift, 1 nibble fold |
| hostReq | input | 1 | Host access request, held until acknowledged |
| hostWrite | input | 1 | 1 for write, 0 for read |
| hostAddr | input | ADDR_W | Host byte address |
| hostWdata | input | DATA_W | Host write data, big-endian |
| hostAck | output | 1 | One-cycle completion pulse |
| hostRdata | output | DATA_W | Read data, valid with `hostAck` |
| dnReqValid | output | 1 | Downstream request valid |
| dnReqReady | input | 1 | Downstream request accepted |
| dnWrite | output | 1 | Downstream access is a write |
| dnAddr | output | WIN_BITS | Downstream byte address (index << 3) |
| dnWdata | output | DATA_W | Downstream write data |
| dnRspValid | input | 1 | Downstream response valid |
| dnRspErr | input | 1 | Downstream response error |
| dnRspData | input | DATA_W | Downstream read data |
| statClr | input | 2 | Write-one-to-clear: bit 0 done, bit 1 fail |
| statDone | output | 1 | Sticky completion bit |
| statFail | output | 1 | Sticky failure bit |

## Verification
The assertions assume the downstream side returns a response only after it has accepted a request, and that the host drops `hostReq` in the acknowledge cycle so that a held request is not taken as a second access. The bench's downstream model raises its response only after completing the ready handshake, with programmable ready and response delays. The host task lowers its request on the same negative edge where it observes `hostAck`. Status clears are pulsed only while no access is in flight.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;      // latch host access
    logic finishLocal;  // complete from intercept table
    logic finishFwd;    // complete from downstream response
  } ctlStrb_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_REQ,
    ST_RSP,
    ST_ACK
  } ctlState_t;

endpackage

// File: rtl/regbus_icept.sv
module regbus_icept #(
  parameter int IDX_W = 29
) (
  input  logic [IDX_W-1:0] idx,
  output logic             chipIdHit,
  output logic             zeroReadHit,
  output logic             dropWriteHit
);

  localparam logic [IDX_W-1:0] IX_CHIPID   = IDX_W'(32'h000F_000F);
  localparam logic [IDX_W-1:0] IX_FLT_LO   = IDX_W'(32'h0101_0C00);
  localparam logic [IDX_W-1:0] IX_FLT_MSK  = IDX_W'(32'h0101_0C03);
  localparam logic [IDX_W-1:0] IX_FLT_HI   = IDX_W'(32'h0101_0C05);
  localparam logic [IDX_W-1:0] IX_ADA      = IDX_W'(32'h0202_0007);
  localparam logic [IDX_W-1:0] IX_ADB      = IDX_W'(32'h0202_0009);
  localparam logic [IDX_W-1:0] IX_ADC      = IDX_W'(32'h0202_000F);
  localparam logic [IDX_W-1:0] IX_WIN_LO   = IDX_W'(32'h0201_3F00);
  localparam logic [IDX_W-1:0] IX_WIN_HI   = IDX_W'(32'h0201_3F07);
  localparam logic [IDX_W-1:0] IX_CPA      = IDX_W'(32'h0201_3028);
  localparam logic [IDX_W-1:0] IX_CPB      = IDX_W'(32'h0201_302A);
  localparam logic [IDX_W-1:0] IX_CPC      = IDX_W'(32'h0201_3801);
  localparam logic [IDX_W-1:0] IX_CPD      = IDX_W'(32'h0201_3802);

  logic adHit;

  always_comb begin
    adHit        = (idx == IX_ADA) || (idx == IX_ADB) || (idx == IX_ADC);
    chipIdHit    = (idx == IX_CHIPID);
    zeroReadHit  = adHit
                 || (idx == IX_FLT_LO) || (idx == IX_FLT_MSK)
                 || ((idx >= IX_WIN_LO) && (idx <= IX_WIN_HI))
                 || (idx == IX_CPA) || (idx == IX_CPB)
                 || (idx == IX_CPC) || (idx == IX_CPD);
    dropWriteHit = adHit || chipIdHit
                 || ((idx >= IX_FLT_LO) && (idx <= IX_FLT_HI));
  end

endmodule

// File: rtl/regbus_dp.sv
module regbus_dp
  import regbus_pkg::*;
#(
  parameter int          ADDR_W   = 64,
  parameter int          WIN_BITS = 32,
  parameter int          DATA_W   = 64,
  parameter logic [63:0] CHIP_ID  = 64'h0000_0000_120D_3049
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrb_t            strb,
  input  logic                modeSel,
  input  logic                hostWrite,
  input  logic [ADDR_W-1:0]   hostAddr,
  input  logic [DATA_W-1:0]   hostWdata,
  input  logic                dnRspErr,
  input  logic [DATA_W-1:0]   dnRspData,
  input  logic [1:0]          statClr,
  output logic                localHit,
  output logic                dnWrite,
  output logic [WIN_BITS-1:0] dnAddr,
  output logic [DATA_W-1:0]   dnWdata,
  output logic [DATA_W-1:0]   hostRdata,
  output logic                statDone,
  output logic                statFail
);

  localparam int IDX_W  = WIN_BITS - 3;
  localparam int FOLD_W = WIN_BITS - 4;

  logic [WIN_BITS-1:0] winAddr;
  logic [IDX_W-1:0]    foldA;
  logic [IDX_W-1:0]    foldB;
  logic [IDX_W-1:0]    newIdx;
  logic [IDX_W-1:0]    capIdx;
  logic                capWrite;
  logic [DATA_W-1:0]   capWdata;
  logic [DATA_W-1:0]   rdataQ;
  logic                doneQ;
  logic                failQ;
  logic                chipIdHit;
  logic                zeroReadHit;
  logic                dropWriteHit;
  logic [DATA_W-1:0]   localRdata;
  logic                unusedAddr;

  // Window mask and both folding schemes
  always_comb begin
    winAddr    = hostAddr[WIN_BITS-1:0];
    foldA      = winAddr[WIN_BITS-1:3];
    foldB      = IDX_W'({winAddr[WIN_BITS-1:8], winAddr[6:3]});
    newIdx     = modeSel ? foldB : foldA;
    unusedAddr = ^{hostAddr[ADDR_W-1:WIN_BITS], winAddr[2:0], FOLD_W'(0)};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capIdx   <= '0;
      capWrite <= 1'b0;
      capWdata <= '0;
    end else if (strb.capture) begin
      capIdx   <= newIdx;
      capWrite <= hostWrite;
      capWdata <= hostWdata;
    end
  end

  regbus_icept #(.IDX_W(IDX_W)) uIcept (
    .idx          (capIdx),
    .chipIdHit    (chipIdHit),
    .zeroReadHit  (zeroReadHit),
    .dropWriteHit (dropWriteHit)
  );

  always_comb begin
    localHit   = capWrite ? dropWriteHit : (chipIdHit || zeroReadHit);
    localRdata = chipIdHit ? DATA_W'(CHIP_ID) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdataQ <= '0;
    end else if (strb.finishLocal) begin
      rdataQ <= capWrite ? '0 : localRdata;
    end else if (strb.finishFwd) begin
      rdataQ <= (capWrite || dnRspErr) ? '0 : dnRspData;
    end
  end

  // Sticky status: setting wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneQ <= 1'b0;
      failQ <= 1'b0;
    end else begin
      doneQ <= (doneQ && !statClr[0]) || strb.finishLocal || strb.finishFwd;
      failQ <= (failQ && !statClr[1]) || (strb.finishFwd && dnRspErr);
    end
  end

  assign dnAddr    = {capIdx, 3'b000};
  assign dnWrite   = capWrite;
  assign dnWdata   = capWdata;
  assign hostRdata = rdataQ;
  assign statDone  = doneQ;
  assign statFail  = failQ;

  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && !statClr[0]) |=> doneQ);

  a_r9_fail_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (failQ && !statClr[1]) |=> failQ);

  a_r8_err_sets_both: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finishFwd && dnRspErr) |=> (failQ && doneQ));

  a_r7_idx_held: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(capIdx));

endmodule

// File: rtl/regbus_ctl.sv
module regbus_ctl
  import regbus_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     hostReq,
  input  logic     localHit,
  input  logic     dnReqReady,
  input  logic     dnRspValid,
  output ctlStrb_t strb,
  output logic     dnReqValid,
  output logic     hostAck
);

  ctlState_t stateQ;
  ctlState_t stateD;

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    unique case (stateQ)
      ST_IDLE: if (hostReq) begin
        strb.capture = 1'b1;
        stateD       = ST_LOOK;
      end
      ST_LOOK: if (localHit) begin
        strb.finishLocal = 1'b1;
        stateD           = ST_ACK;
      end else begin
        stateD = ST_REQ;
      end
      ST_REQ: if (dnReqReady) stateD = ST_RSP;
      ST_RSP: if (dnRspValid) begin
        strb.finishFwd = 1'b1;
        stateD         = ST_ACK;
      end
      ST_ACK:  stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign dnReqValid = (stateQ == ST_REQ);
  assign hostAck    = (stateQ == ST_ACK);

  a_r5_local_no_req: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_LOOK && localHit) |=> !dnReqValid);

  a_r7_valid_hold: assert property (@(posedge clk) disable iff (!rstN)
    (dnReqValid && !dnReqReady) |=> dnReqValid);

  a_r11_ack_pulse: assert property (@(posedge clk) disable iff (!rstN)
    hostAck |=> !hostAck);

  a_r7_single_req: assert property (@(posedge clk) disable iff (!rstN)
    (dnReqValid && dnReqReady) |=> !dnReqValid);

endmodule

// File: rtl/regbus_bridge.sv
module regbus_bridge
  import regbus_pkg::*;
#(
  parameter int          ADDR_W   = 64,
  parameter int          WIN_BITS = 32,
  parameter int          DATA_W   = 64,
  parameter logic [63:0] CHIP_ID  = 64'h0000_0000_120D_3049
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                modeSel,
  input  logic                hostReq,
  input  logic                hostWrite,
  input  logic [ADDR_W-1:0]   hostAddr,
  input  logic [DATA_W-1:0]   hostWdata,
  output logic                hostAck,
  output logic [DATA_W-1:0]   hostRdata,
  output logic                dnReqValid,
  input  logic                dnReqReady,
  output logic                dnWrite,
  output logic [WIN_BITS-1:0] dnAddr,
  output logic [DATA_W-1:0]   dnWdata,
  input  logic                dnRspValid,
  input  logic                dnRspErr,
  input  logic [DATA_W-1:0]   dnRspData,
  input  logic [1:0]          statClr,
  output logic                statDone,
  output logic                statFail
);

  ctlStrb_t strb;
  logic     localHit;

  regbus_ctl uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .hostReq    (hostReq),
    .localHit   (localHit),
    .dnReqReady (dnReqReady),
    .dnRspValid (dnRspValid),
    .strb       (strb),
    .dnReqValid (dnReqValid),
    .hostAck    (hostAck)
  );

  regbus_dp #(
    .ADDR_W   (ADDR_W),
    .WIN_BITS (WIN_BITS),
    .DATA_W   (DATA_W),
    .CHIP_ID  (CHIP_ID)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .modeSel   (modeSel),
    .hostWrite (hostWrite),
    .hostAddr  (hostAddr),
    .hostWdata (hostWdata),
    .dnRspErr  (dnRspErr),
    .dnRspData (dnRspData),
    .statClr   (statClr),
    .localHit  (localHit),
    .dnWrite   (dnWrite),
    .dnAddr    (dnAddr),
    .dnWdata   (dnWdata),
    .hostRdata (hostRdata),
    .statDone  (statDone),
    .statFail  (statFail)
  );

endmodule

// File: tb/tb_regbus_bridge.sv
module tb_regbus_bridge;

  localparam logic [63:0] CID = 64'h0000_0000_120D_3049;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeSel = 1'b0;
  logic        hostReq = 1'b0;
  logic        hostWrite = 1'b0;
  logic [63:0] hostAddr = '0;
  logic [63:0] hostWdata = '0;
  logic        hostAck;
  logic [63:0] hostRdata;
  logic        dnReqValid;
  logic        dnReqReady = 1'b0;
  logic        dnWrite;
  logic [31:0] dnAddr;
  logic [63:0] dnWdata;
  logic        dnRspValid = 1'b0;
  logic        dnRspErr = 1'b0;
  logic [63:0] dnRspData = '0;
  logic [1:0]  statClr = 2'b00;
  logic        statDone;
  logic        statFail;

  int checks = 0;
  int failures = 0;

  // downstream model state
  int          dnCount = 0;
  logic [31:0] lastAddr = '0;
  logic        lastWrite = 1'b0;
  logic [63:0] lastWdata = '0;
  int          readyDelay = 0;
  int          rspDelay = 0;
  logic        errNext = 1'b0;

  always #2.5 clk = ~clk;

  regbus_bridge #(.CHIP_ID(CID)) dut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .hostReq(hostReq),
    .hostWrite(hostWrite), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostAck(hostAck), .hostRdata(hostRdata), .dnReqValid(dnReqValid),
    .dnReqReady(dnReqReady), .dnWrite(dnWrite), .dnAddr(dnAddr),
    .dnWdata(dnWdata), .dnRspValid(dnRspValid), .dnRspErr(dnRspErr),
    .dnRspData(dnRspData), .statClr(statClr), .statDone(statDone),
    .statFail(statFail)
  );

  function automatic logic [63:0] rspFor(input logic [31:0] a);
    return {32'hC0DE_0000 ^ a, a};
  endfunction

  function automatic logic [31:0] expAddr(input logic mode, input logic [63:0] a);
    logic [31:0] m = a[31:0];
    logic [31:0] idx;
    if (mode) idx = ((m >> 4) & ~32'hF) | ((m >> 3) & 32'hF);
    else      idx = m >> 3;
    return idx << 3;
  endfunction

  // downstream register port model
  initial begin
    forever begin
      @(negedge clk);
      if (dnReqValid) begin
        repeat (readyDelay) @(negedge clk);
        dnReqReady = 1'b1;
        lastAddr   = dnAddr;
        lastWrite  = dnWrite;
        lastWdata  = dnWdata;
        dnCount++;
        @(negedge clk);
        dnReqReady = 1'b0;
        repeat (rspDelay) @(negedge clk);
        dnRspValid = 1'b1;
        dnRspErr   = errNext;
        dnRspData  = rspFor(lastAddr);
        @(negedge clk);
        dnRspValid = 1'b0;
        dnRspErr   = 1'b0;
      end
    end
  end

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic access(input logic w, input logic [63:0] a, input logic [63:0] wd,
                        output logic [63:0] rd, output int lat);
    @(negedge clk);
    hostReq = 1'b1; hostWrite = w; hostAddr = a; hostWdata = wd;
    lat = 0;
    rd = '0;
    while (lat < 1000) begin
      @(negedge clk);
      lat++;
      if (hostAck) break;
    end
    if (!hostAck) check("R11 ack timeout", 64'(lat), 64'(0));
    rd = hostRdata;
    hostReq = 1'b0;
    @(negedge clk);
    check("R11 ack single pulse", 64'(hostAck), 64'(0));
  endtask

  task automatic clearStatus(input logic [1:0] c);
    @(negedge clk);
    statClr = c;
    @(negedge clk);
    statClr = 2'b00;
  endtask

  task automatic testReset();
    check("R10 ack after reset", 64'(hostAck), 64'(0));
    check("R10 dnReqValid after reset", 64'(dnReqValid), 64'(0));
    check("R10 done after reset", 64'(statDone), 64'(0));
    check("R10 fail after reset", 64'(statFail), 64'(0));
  endtask

  task automatic testChipId();
    logic [63:0] rd; int lat; int c0;
    modeSel = 1'b0;
    c0 = dnCount;
    access(1'b0, 64'h0078_0078, '0, rd, lat);
    check("R4 chip id readback", rd, CID);
    check("R4 no downstream", 64'(dnCount - c0), 64'(0));
    check("R11 local latency", 64'(lat), 64'(2));
    check("R9 done after local", 64'(statDone), 64'(1));
    check("R9 fail stays clear", 64'(statFail), 64'(0));
    clearStatus(2'b01);
    check("R9 done cleared", 64'(statDone), 64'(0));
  endtask

  task automatic testZeroReads();
    logic [63:0] rd; int lat; int c0;
    modeSel = 1'b0;
    c0 = dnCount;
    access(1'b0, 64'(32'h0201_3F05) << 3, '0, rd, lat);
    check("R5 window read zero", rd, 64'(0));
    access(1'b0, 64'(32'h0101_0C03) << 3, '0, rd, lat);
    check("R5 mask read zero", rd, 64'(0));
    access(1'b0, 64'(32'h0201_3802) << 3, '0, rd, lat);
    check("R5 last entry read zero", rd, 64'(0));
    check("R5 no downstream", 64'(dnCount - c0), 64'(0));
  endtask

  task automatic testDropWrites();
    logic [63:0] rd; int lat; int c0;
    modeSel = 1'b0;
    c0 = dnCount;
    access(1'b1, 64'(32'h0101_0C04) << 3, 64'h1111, rd, lat);
    access(1'b1, 64'(32'h000F_000F) << 3, 64'h2222, rd, lat);
    check("R6 dropped writes no downstream", 64'(dnCount - c0), 64'(0));
    access(1'b0, 64'(32'h0101_0C01) << 3, '0, rd, lat);
    check("R6 read of write-only entry forwarded", 64'(dnCount - c0), 64'(1));
    check("R6 forwarded addr", 64'(lastAddr), 64'(32'h0101_0C01) << 3);
    check("R6 forwarded read data", rd, rspFor(32'h0808_6008));
    access(1'b1, 64'(32'h0201_3F00) << 3, 64'hDEAD_BEEF_0123_4567, rd, lat);
    check("R5 write to read-zero entry forwarded", 64'(dnCount - c0), 64'(2));
    check("R7 write flag", 64'(lastWrite), 64'(1));
    check("R7 write data", lastWdata, 64'hDEAD_BEEF_0123_4567);
  endtask

  task automatic testModeA();
    logic [63:0] rd; int lat; int c0;
    logic [63:0] a = 64'hFFFF_FFF0_0000_123F;
    modeSel = 1'b0;
    c0 = dnCount;
    readyDelay = 3; rspDelay = 2;
    access(1'b0, a, '0, rd, lat);
    readyDelay = 0; rspDelay = 0;
    check("R1 R3 mode A addr", 64'(lastAddr), 64'(expAddr(1'b0, a)));
    check("R1 mode A addr value", 64'(lastAddr), 64'h1238);
    check("R7 one request with ready delay", 64'(dnCount - c0), 64'(1));
    check("R8 forwarded read data", rd, rspFor(32'h1238));
  endtask

  task automatic testModeB();
    logic [63:0] rd; int lat; int c0;
    logic [63:0] a = 64'hABCD_0000_1234_56F8;
    modeSel = 1'b1;
    c0 = dnCount;
    access(1'b0, a, '0, rd, lat);
    check("R2 mode B addr", 64'(lastAddr), 64'(expAddr(1'b1, a)));
    check("R2 mode B addr value", 64'(lastAddr), 64'h091A_2B78);
    access(1'b0, 64'h00F0_00F8, '0, rd, lat);
    check("R2 mode B chip id bit7 ignored", rd, CID);
    access(1'b0, 64'h00F0_0078, '0, rd, lat);
    check("R2 mode B chip id", rd, CID);
    check("R2 mode B local no downstream", 64'(dnCount - c0), 64'(1));
    modeSel = 1'b0;
  endtask

  task automatic testError();
    logic [63:0] rd; int lat;
    clearStatus(2'b11);
    errNext = 1'b1;
    access(1'b0, 64'h5008, '0, rd, lat);
    errNext = 1'b0;
    check("R8 error read zero", rd, 64'(0));
    check("R8 error fail", 64'(statFail), 64'(1));
    check("R8 error done", 64'(statDone), 64'(1));
    access(1'b0, 64'h6010, '0, rd, lat);
    check("R9 fail sticky after success", 64'(statFail), 64'(1));
    check("R8 good read after error", rd, rspFor(32'h6010));
    clearStatus(2'b10);
    check("R9 fail cleared alone", 64'(statFail), 64'(0));
    check("R9 done unaffected by fail clear", 64'(statDone), 64'(1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testChipId();
    testZeroReads();
    testDropWrites();
    testModeA();
    testModeB();
    testError();
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule